// File: doc/BRIEF.md
# Stretched External Data Memory Sequencer

This block runs one read or write cycle on a multiplexed external memory bus. The low address byte and the data byte share one 8-bit port. The high address byte has its own port. An address latch enable pulse marks the cycle in which the shared port carries the low address. After that, the block asserts the active-low read or write strobe. During a write it drives the data on the shared port. During a read it releases the shared port and samples the value that the memory returns. The program-store enable output stays inactive for the whole access, because only data memory is addressed.

The strobe phase lasts one machine cycle plus a number of extra cycles. A 3-bit stretch code sets that number, and its meaning depends on the bus mode. In normal mode the code is the extra-cycle count itself (0 to 7). In page mode 1 the codes 0 to 3 still add 0 to 3 cycles, but the codes 4 to 7 add 7 to 10 cycles. One clock of this block is one machine cycle. An unstretched access therefore takes two cycles: one address cycle and one strobe cycle.

Requests come in on a valid/ready handshake. `req_ready` is high only while the sequencer is idle, which includes the cycle in which `done` pulses. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The source must hold the request and its fields until that edge. Any request made while `req_ready` is low is not taken. A request that is still held in the `done` cycle is taken at once, so accesses can run back to back. The address, write data, direction, stretch code and mode are captured at acceptance.

Top module: `xmem_seq`

## Requirements
- R1: While reset is applied and after it, `ale`=0, `rd_n`=1, `wr_n`=1, `psen_n`=1, `ad_oe`=0, `done`=0 and `req_ready`=1.
- R2: A request is accepted on a clock edge with `req_valid`=1 and `req_ready`=1. From the next cycle `req_ready` is 0 until the cycle in which `done` is 1, where it returns to 1.
- R3: In the cycle after acceptance, `ale`=1, `ad_oe`=1, `ad_out`=address[7:0], `addr_hi`=address[15:8], and both strobes are 1.
- R4: With `page_mode1`=0, the strobe stays low for 1+code cycles for every code 0 to 7.
- R5: With `page_mode1`=1, the strobe stays low for 1+code cycles for codes 0 to 3, and for 8, 9, 10 or 11 cycles for codes 4, 5, 6 or 7.
- R6: For a write (`req_write`=1), `wr_n` is 0 and `rd_n` is 1 during the strobe phase, with `ad_oe`=1 and `ad_out` equal to the write data.
- R7: For a read (`req_write`=0), `rd_n` is 0 and `wr_n` is 1 during the strobe phase, and `ad_oe`=0. `rd_data` holds the value of `ad_in` from the last cycle in which `rd_n` is 0, and it is valid while `done` is 1.
- R8: `done` is high for exactly one cycle: the first cycle after the last strobe cycle. An unstretched access takes two cycles, from the address cycle to the end of the strobe.
- R9: `psen_n` stays 1 at all times, including during data accesses.
- R10: A request presented while `req_ready`=0 and withdrawn before `done` starts no access. No further `ale` pulse follows, and the address of the current access does not change.
- R11: After acceptance, changes on `req_addr`, `req_wdata`, `req_write`, `stretch` or `page_mode1` do not affect the access in progress.
- R12: If `req_valid` is held high through the `done` cycle, the new request is accepted at the end of that cycle, and `ale` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data memory address |
| req_wdata | input | 8 | Write data |
| stretch | input | 3 | Stretch code |
| page_mode1 | input | 1 | 1 selects the page-mode-1 stretch mapping |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store enable, held inactive |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_out | output | 8 | Shared port: low address or write data |
| ad_oe | output | 1 | Output enable for the shared port |
| ad_in | input | 8 | Shared port value returned by the memory |
| addr_hi | output | 8 | High address byte port |
| rd_data | output | 8 | Captured read data |
| done | output | 1 | One-cycle access-complete pulse |

## Verification
The case that matters most is the cycle in which `done` pulses while the next request is already waiting. In that one cycle, completion and acceptance both take place. The bench holds `req_valid` high with new fields through a short access. It then checks that `done` and `req_ready` are both high in the same cycle, and that the following cycle shows `ale` with the new address and `done` low. A separate test raises a request in the middle of a stretched access and drops it before completion. After `done`, the bench checks that no address phase starts and that the high address byte is unchanged.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2
  } xmem_phase_e;
endpackage

// File: rtl/xmem_stretch_map.sv
module xmem_stretch_map #(
  parameter int CODE_W    = 3,
  parameter int CNT_W     = 4,
  parameter int PAGE_BASE = 7
) (
  input  logic [CODE_W-1:0] code,
  input  logic              page_mode1,
  output logic [CNT_W-1:0]  extra
);
  localparam int HALF = 1 << (CODE_W - 1);

  always_comb begin
    if (page_mode1 && code[CODE_W-1])
      extra = CNT_W'(code) - CNT_W'(HALF) + CNT_W'(PAGE_BASE);
    else
      extra = CNT_W'(code);
  end
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] extra,
  output logic             req_ready,
  output logic             accept,
  output logic             in_addr,
  output logic             in_strb,
  output logic             last,
  output logic             done
);
  xmem_phase_e     phase;
  logic [CNT_W-1:0] cnt;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_addr   = (phase == PH_ADDR);
  assign in_strb   = (phase == PH_STRB);
  assign last      = in_strb && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          phase <= PH_ADDR;
          cnt   <= extra;
        end
        PH_ADDR: phase <= PH_STRB;
        PH_STRB: begin
          if (cnt == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion directly follows a strobe cycle
  assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_strb) && !in_strb);
endmodule

// File: rtl/xmem_bus.sv
module xmem_bus #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 in_addr,
  input  logic                 in_strb,
  input  logic                 last,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W-1:0]    ad_in,
  output logic                 ale,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic [DATA_W-1:0]    ad_out,
  output logic                 ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]    rd_data
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (last && !wr_q)
      rd_data <= ad_in;
  end

  assign ale     = in_addr;
  assign rd_n    = !(in_strb && !wr_q);
  assign wr_n    = !(in_strb && wr_q);
  assign ad_oe   = in_addr || (in_strb && wr_q);
  assign ad_out  = in_addr ? addr_q[DATA_W-1:0] : wdata_q;
  assign addr_hi = addr_q[ADDR_W-1:DATA_W];

  // R7: the shared port is released while reading
  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R11: address and port data hold across consecutive strobe cycles
  assert_hold_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)) |-> ($stable(addr_hi) && $stable(ad_out)));
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 3,
  parameter int PAGE_BASE = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [CODE_W-1:0]        stretch,
  input  logic                     page_mode1,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     done
);
  localparam int HALF       = 1 << (CODE_W - 1);
  localparam int NORM_MAX   = (1 << CODE_W) - 1;
  localparam int PAGE_MAX   = HALF - 1 + PAGE_BASE;
  localparam int EXTRA_MAX  = (PAGE_MAX > NORM_MAX) ? PAGE_MAX : NORM_MAX;
  localparam int CNT_W      = $clog2(EXTRA_MAX + 1);

  logic [CNT_W-1:0] extra;
  logic accept, in_addr, in_strb, last;

  xmem_stretch_map #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .PAGE_BASE(PAGE_BASE)
  ) map_i (
    .code(stretch), .page_mode1(page_mode1), .extra(extra)
  );

  xmem_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .extra(extra),
    .req_ready(req_ready), .accept(accept), .in_addr(in_addr),
    .in_strb(in_strb), .last(last), .done(done)
  );

  xmem_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_addr(in_addr),
    .in_strb(in_strb), .last(last), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .rd_data(rd_data)
  );

  assign psen_n = 1'b1;

  // R3: an accepted request is followed by the address cycle
  assert_accept_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ale && ad_oe && rd_n && wr_n));

  // R10: no request can be taken while the bus is active
  assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !rd_n || !wr_n) |-> !req_ready);

  // R12: a request waiting in the completion cycle starts the next address cycle
  assert_back_to_back_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_valid) |=> ale);
endmodule

// File: tb/xmem_seq_tb.sv
module xmem_seq_tb_top;
  typedef struct packed {
    logic        wr;
    logic        pm;
    logic [2:0]  code;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [4:0]  len;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd0, 16'h1234, 8'hA5, 5'd1},
    '{1'b0, 1'b0, 3'd0, 16'hBEEF, 8'h3C, 5'd1},
    '{1'b1, 1'b0, 3'd3, 16'h00FF, 8'h5A, 5'd4},
    '{1'b0, 1'b0, 3'd5, 16'hFF00, 8'h11, 5'd6},
    '{1'b0, 1'b0, 3'd7, 16'h8001, 8'h22, 5'd8},
    '{1'b1, 1'b1, 3'd2, 16'h4242, 8'h99, 5'd3},
    '{1'b0, 1'b1, 3'd4, 16'h7E81, 8'h40, 5'd8},
    '{1'b1, 1'b1, 3'd5, 16'h0001, 8'h66, 5'd9},
    '{1'b0, 1'b1, 3'd7, 16'hC3C3, 8'h80, 5'd11},
    '{1'b1, 1'b1, 3'd6, 16'hA0A0, 8'hF0, 5'd10},
    '{1'b1, 1'b0, 3'd4, 16'h1111, 8'h0F, 5'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, page_mode1 = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0;
  logic [2:0]  stretch = '0;
  logic req_ready, ale, psen_n, rd_n, wr_n, ad_oe, done;
  logic [7:0] ad_out, addr_hi, rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xmem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .stretch(stretch), .page_mode1(page_mode1), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input vec_t v);
    int n;
    bit stb;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
    req_wdata = v.data; stretch = v.code; page_mode1 = v.pm;
    chk(req_ready == 1'b1, "R2 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~v.wr; req_addr = ~v.addr;
    req_wdata = ~v.data; stretch = ~v.code; page_mode1 = ~v.pm;
    chk(ale && ad_oe && rd_n && wr_n, "R3 address phase controls", {ale, ad_oe, rd_n, wr_n}, 4'hF);
    chk(ad_out == v.addr[7:0], "R3 low address", ad_out, v.addr[7:0]);
    chk(addr_hi == v.addr[15:8], "R3 high address", addr_hi, v.addr[15:8]);
    chk(req_ready == 1'b0, "R2 busy", req_ready, 0);
    chk(psen_n == 1'b1, "R9 psen inactive", psen_n, 1);
    n = 0;
    stb = 1'b1;
    while (stb && n < 20) begin
      @(negedge clk);
      stb = !rd_n || !wr_n;
      if (stb) begin
        ad_in = v.data + 8'(n);
        if (v.wr) begin
          chk(!wr_n && rd_n && ad_oe && ad_out == v.data, "R6 write strobe",
              {rd_n, wr_n, ad_oe, ad_out}, {3'b101, v.data});
        end else begin
          chk(!rd_n && wr_n && !ad_oe, "R7 read strobe", {rd_n, wr_n, ad_oe}, 3'b010);
        end
        chk(addr_hi == v.addr[15:8] && psen_n && !done && !ale, "R11 held fields",
            {psen_n, done, ale, addr_hi}, {3'b100, v.addr[15:8]});
        n++;
      end
    end
    if (v.pm)
      chk(n == int'(v.len), "R5 page mode strobe width", n, v.len);
    else
      chk(n == int'(v.len), "R4 normal strobe width", n, v.len);
    chk(done && req_ready && !ale, "R8 done pulse", {done, req_ready, ale}, 3'b110);
    if (!v.wr)
      chk(rd_data == v.data + 8'(v.len - 1), "R7 read data", rd_data, v.data + 8'(v.len - 1));
    @(negedge clk);
    ad_in = '0;
    chk(!done && !ale, "R8 done single", {done, ale}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t w;
    int n;
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && psen_n && !ad_oe && !done && req_ready, "R1 in reset",
        {ale, rd_n, wr_n, psen_n, ad_oe, done, req_ready}, 7'b0111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !done && req_ready, "R1 after reset",
        {ale, rd_n, wr_n, done, req_ready}, 5'b01101);

    for (int i = 0; i < NV; i++) run_access(VECS[i]);

    // R10: request raised and dropped mid-access is ignored
    w = '{1'b0, 1'b0, 3'd3, 16'h5555, 8'h30, 5'd4};
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = w.addr; stretch = w.code; page_mode1 = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h9999;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R10 first access completes", done, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!ale && rd_n && wr_n && req_ready && addr_hi == 8'h55, "R10 no extra access",
          {ale, rd_n, wr_n, req_ready, addr_hi}, {4'b0111, 8'h55});
    end

    // R12: back-to-back, completion and acceptance in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2233; req_wdata = 8'h44;
    stretch = 3'd0; page_mode1 = 1'b0;
    @(negedge clk);
    chk(ale && addr_hi == 8'h22, "R12 first address", {ale, addr_hi}, {1'b1, 8'h22});
    req_addr = 16'h6677; req_wdata = 8'h88; req_write = 1'b0;
    @(negedge clk);
    chk(!wr_n && ad_out == 8'h44, "R12 first write data", {wr_n, ad_out}, {1'b0, 8'h44});
    @(negedge clk);
    chk(done && req_ready, "R12 done with ready", {done, req_ready}, 2'b11);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ale && !done && ad_out == 8'h77 && addr_hi == 8'h66, "R12 second address",
        {ale, done, addr_hi, ad_out}, {2'b10, 16'h6677});
    @(negedge clk);
    chk(!rd_n && wr_n, "R12 second is read", {rd_n, wr_n}, 2'b01);
    @(negedge clk);
    chk(done, "R12 second done", done, 1);
    @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule